// File: doc/BRIEF.md
# Byte-to-Longword DMA Burst Packer

This block moves a programmed number of bytes from an 8-bit producer into memory over a 32-bit local bus, acting as the bus master. Bytes arrive on a valid/ready port and are packed into 32-bit words. The packed words wait in a small word FIFO. Writes go out as four-beat bursts whenever four or more words are waiting. The bytes that do not fill a whole burst at the end of the job leave as single-beat writes.

Software loads a start address, a byte count and a parity-enable bit, then pulses `start`. The block returns a one-cycle `done` pulse when the last write has been accepted. The first beat of every bus transfer takes a fixed number of acknowledged clocks, and that number depends on whether parity is on. Each later beat of a burst takes one acknowledged clock. The bus slave inserts wait states by dropping `bus_ack`.

Top module: `dma_burst_packer`

## Requirements
- R1: Bytes are packed little-endian. The first byte of each group of four goes to bits [7:0], the next to [15:8], then [23:16], then [31:24]. A final word that is only partly filled carries zeros in its unused upper lanes.
- R2: A burst is exactly four beats with `bus_burst` high, and `bus_req` stays high from the first beat to the last. The address rises by 4 on each beat, and each beat carries the next packed word in order.
- R3: A beat advances only on clocks where `bus_req` and `bus_ack` are both high. The first beat of a transfer needs 4 such clocks when `parity_en` is 0 and 5 when it is 1. Each later beat of a burst needs 1. `parity_en` is sampled when the transfer is launched.
- R4: The low four bits of `start_addr` are ignored. The first write goes to `{start_addr[31:4],4'h0}`, and later writes follow on contiguously.
- R5: A burst is requested only when the FIFO already holds four packed words. No burst starts before all of its sixteen bytes have been accepted on the byte port.
- R6: Words left over after the last full burst (fewer than four) are written one at a time with `bus_burst` low, and only after every byte of the count has been accepted. Each such write uses the first-beat latency of R3, and `bus_req` drops after each one.
- R7: `in_ready` is low while the FIFO is full. With a FIFO depth of 8 words and the bus stalled, exactly 32 bytes are accepted.
- R8: `done` is high for exactly one clock. It rises on the second clock edge after the edge that completes the final write.
- R9: A byte count of zero issues no bus request, and `done` pulses on the second edge after the edge that accepts `start`.
- R10: A `start` pulse while a job is active has no effect. The running job keeps its address, its count and its data.
- R11: While reset is held, and directly after it, `bus_req`, `done` and `in_ready` are low.
- R12: `in_ready` is low while no job is active, and low once all bytes of the count have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a job when the block is idle |
| start_addr | input | 32 | Destination address; low four bits ignored |
| byte_count | input | 16 | Number of bytes in the job |
| parity_en | input | 1 | Selects the longer first-beat latency |
| in_valid | input | 1 | Byte available from the producer |
| in_data | input | 8 | Byte from the producer |
| in_ready | output | 1 | Block can take a byte this clock |
| bus_req | output | 1 | Write request / transfer in progress |
| bus_ack | input | 1 | Slave ready; low inserts a wait state |
| bus_addr | output | 32 | Address of the current beat |
| bus_data | output | 32 | Data of the current beat |
| bus_burst | output | 1 | Current transfer is a four-beat burst |
| done | output | 1 | One-clock pulse at the end of the job |

## Verification
The ports expose three internal states: a lane pointer, the word FIFO pointers and the beat wait counter. A lane pointer that slips shows up as rotated bytes in the very next word written. A FIFO pointer fault puts a stale or repeated word on `bus_data` at the first beat after the fault. A wait counter loaded with the wrong value moves the address to the next beat one acknowledged clock early or late, so a mismatch appears within one beat. A wrong residual-write count shows up as an early, late or missing `done`, or as a request that never ends, within a few clocks of the last write.

// File: rtl/dmap_pkg.sv
// Shared definitions for the byte-to-longword DMA burst packer.
// Assumes: a 32-bit bus word made of four byte lanes.
package dmap_pkg;
    localparam int LANES     = 4;
    localparam int WORD_BITS = 8 * LANES;

    typedef enum logic [0:0] {
        BM_IDLE = 1'b0,
        BM_XFER = 1'b1
    } bm_state_e;
endpackage

// File: rtl/dmap_word_fifo.sv
// Word FIFO between the byte packer and the bus master.
// Head data is shown combinationally. The writer must not push when full
// and the reader must not pop when empty. Any depth of 2 or more works.
module dmap_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNTW-1:0]  count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_next;
    logic [PW-1:0]    rd_next;

    // Pointer wrap: free-running when the depth is a power of two, compared otherwise.
    generate
        if ((1 << PW) == DEPTH) begin : g_pow2
            assign wr_next = wr_ptr + PW'(1);
            assign rd_next = rd_ptr + PW'(1);
        end else begin : g_cmp
            assign wr_next = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            assign rd_next = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
        end
    endgenerate

    assign full  = (count == CNTW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_next;
            if (pop)  rd_ptr <= rd_next;
            case ({push, pop})
                2'b10:   count <= count + CNTW'(1);
                2'b01:   count <= count - CNTW'(1);
                default: count <= count;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dmap_byte_packer.sv
// Byte packer: takes bytes from the producer and writes out 32-bit words,
// filling lane 0 first. The last word of a job goes out partly filled,
// with zeros in its unused lanes. Assumes load arrives only between jobs.
module dmap_byte_packer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    input  logic          fifo_full,
    output logic          push,
    output logic [31:0]   push_word,
    output logic          all_in
);
    logic [CW-1:0] bytes_left;
    logic [1:0]    lane;
    logic [31:0]   acc;
    logic          accept;

    // Handshake and word assembly.
    always_comb begin
        in_ready  = (bytes_left != '0) && !fifo_full;
        accept    = in_valid && in_ready;
        push_word = acc | ({24'd0, in_data} << {lane, 3'b000});
        push      = accept && ((lane == 2'd3) || (bytes_left == CW'(1)));
        all_in    = (bytes_left == '0);
    end

    // Byte counter, lane pointer and partial-word accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_left <= '0;
            lane       <= '0;
            acc        <= '0;
        end else if (load) begin
            bytes_left <= load_count;
            lane       <= '0;
            acc        <= '0;
        end else if (accept) begin
            bytes_left <= bytes_left - CW'(1);
            if (push) begin
                lane <= '0;
                acc  <= '0;
            end else begin
                lane <= lane + 2'd1;
                acc  <= push_word;
            end
        end
    end
endmodule

// File: rtl/dmap_bus_master.sv
// Bus write master. It launches a burst when the FIFO holds BURST_LEN words,
// and single writes for the remainder once every byte is in. It holds each
// beat for its latency, counted in acknowledged clocks.
// Assumes load arrives only while idle with an empty FIFO.
module dmap_bus_master
    import dmap_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int CNTW      = 4,
    parameter int BURST_LEN = 4,
    parameter int LAT_OFF   = 4,
    parameter int LAT_ON    = 5,
    localparam int LATW     = $clog2(LAT_ON + 1),
    localparam int BEATW    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [AW-1:0]        load_addr,
    input  logic [CW-1:0]        load_count,
    input  logic                 parity_en,
    input  logic [CNTW-1:0]      fifo_count,
    input  logic [WORD_BITS-1:0] fifo_head,
    input  logic                 all_in,
    output logic                 pop,
    output logic                 writes_zero,
    output logic                 bus_req,
    output logic [AW-1:0]        bus_addr,
    output logic [WORD_BITS-1:0] bus_data,
    output logic                 bus_burst,
    input  logic                 bus_ack
);
    localparam logic [LATW-1:0] FIRST_OFF = LATW'(LAT_OFF - 1);
    localparam logic [LATW-1:0] FIRST_ON  = LATW'(LAT_ON - 1);

    bm_state_e      state;
    logic [LATW-1:0]  wait_cnt;
    logic [BEATW-1:0] beat_idx;
    logic [CW-1:0]    writes_left;
    logic [CW:0]      rounded;
    logic             launch_burst;
    logic             launch_single;
    logic             beat_done;
    logic             last_beat;

    // Launch decisions and beat completion.
    always_comb begin
        rounded       = {1'b0, load_count} + (CW + 1)'(3);
        launch_burst  = (state == BM_IDLE) && (fifo_count >= CNTW'(BURST_LEN));
        launch_single = (state == BM_IDLE) && !launch_burst && all_in && (fifo_count != '0);
        beat_done     = (state == BM_XFER) && bus_ack && (wait_cnt == '0);
        last_beat     = !bus_burst || (beat_idx == BEATW'(BURST_LEN - 1));
        pop           = beat_done;
        writes_zero   = (writes_left == '0);
        bus_data      = fifo_head;
    end

    // Transfer sequencing, address stepping and write counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= BM_IDLE;
            bus_req     <= 1'b0;
            bus_burst   <= 1'b0;
            bus_addr    <= '0;
            wait_cnt    <= '0;
            beat_idx    <= '0;
            writes_left <= '0;
        end else if (load) begin
            bus_addr    <= {load_addr[AW-1:4], 4'b0000};
            writes_left <= CW'(rounded >> 2);
        end else begin
            case (state)
                BM_IDLE: begin
                    if (launch_burst || launch_single) begin
                        state     <= BM_XFER;
                        bus_req   <= 1'b1;
                        bus_burst <= launch_burst;
                        beat_idx  <= '0;
                        wait_cnt  <= parity_en ? FIRST_ON : FIRST_OFF;
                    end
                end
                BM_XFER: begin
                    if (bus_ack) begin
                        if (wait_cnt == '0) begin
                            bus_addr    <= bus_addr + AW'(4);
                            writes_left <= writes_left - CW'(1);
                            if (last_beat) begin
                                state     <= BM_IDLE;
                                bus_req   <= 1'b0;
                                bus_burst <= 1'b0;
                            end else begin
                                beat_idx <= beat_idx + BEATW'(1);
                            end
                        end else begin
                            wait_cnt <= wait_cnt - LATW'(1);
                        end
                    end
                end
                default: state <= BM_IDLE;
            endcase
        end
    end

    a_r4_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && bus_burst) |-> (bus_addr[3:0] == 4'h0));

    a_r5_burst_has_words: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && bus_burst) |-> (fifo_count >= CNTW'(BURST_LEN)));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !last_beat) |=> (bus_req && bus_addr == $past(bus_addr) + AW'(4)));

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_burst)));
endmodule

// File: rtl/dma_burst_packer.sv
// Top of the byte-to-longword DMA burst packer. It accepts a job while idle,
// then routes the byte packer into the word FIFO and the FIFO into the bus
// master. It pulses done when the last write has been taken.
// Assumes the bus slave holds bus_ack low to insert wait states.
module dma_burst_packer #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int DEPTH     = 8,
    parameter int BURST_LEN = 4,
    parameter int LAT_OFF   = 4,
    parameter int LAT_ON    = 5,
    localparam int CNTW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_count,
    input  logic          parity_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          bus_req,
    input  logic          bus_ack,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_data,
    output logic          bus_burst,
    output logic          done
);
    logic            active;
    logic            load;
    logic            push;
    logic [31:0]     push_word;
    logic            pop;
    logic [31:0]     head;
    logic [CNTW-1:0] fifo_count;
    logic            fifo_full;
    logic            fifo_empty;
    logic            all_in;
    logic            writes_zero;

    assign load = start && !active;

    // Job lifetime and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                active <= 1'b1;
            end else if (active && writes_zero) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    dmap_byte_packer #(.CW(CW)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_count (byte_count),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_word  (push_word),
        .all_in     (all_in)
    );

    dmap_word_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_word),
        .pop       (pop),
        .head      (head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    dmap_bus_master #(
        .AW(AW), .CW(CW), .CNTW(CNTW), .BURST_LEN(BURST_LEN),
        .LAT_OFF(LAT_OFF), .LAT_ON(LAT_ON)
    ) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_addr   (start_addr),
        .load_count  (byte_count),
        .parity_en   (parity_en),
        .fifo_count  (fifo_count),
        .fifo_head   (head),
        .all_in      (all_in),
        .pop         (pop),
        .writes_zero (writes_zero),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_data    (bus_data),
        .bus_burst   (bus_burst),
        .bus_ack     (bus_ack)
    );

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_ready_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !fifo_full);

    a_r12_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !in_ready);

    a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !fifo_empty) |-> 1'b0);
endmodule

// File: tb/dma_burst_packer_bench.sv
`timescale 1ns/1ps
module dma_burst_packer_bench;
    typedef struct packed {
        logic [15:0] cnt;
        logic        par;
        logic [31:0] base;
        logic [1:0]  ackm;
        logic        gap;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd16, 1'b0, 32'h0000_1000, 2'd0, 1'b0, 8'h10},
        '{16'd16, 1'b1, 32'h0000_2000, 2'd0, 1'b0, 8'h21},
        '{16'd64, 1'b0, 32'h2000_0040, 2'd1, 1'b0, 8'h32},
        '{16'd7,  1'b0, 32'h0000_3000, 2'd0, 1'b0, 8'h43},
        '{16'd21, 1'b1, 32'h0000_03F7, 2'd2, 1'b0, 8'h54},
        '{16'd1,  1'b1, 32'h0000_4008, 2'd0, 1'b0, 8'h65},
        '{16'd48, 1'b0, 32'h0000_5000, 2'd2, 1'b1, 8'h76},
        '{16'd35, 1'b0, 32'h0000_600C, 2'd1, 1'b1, 8'h87}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] byte_count = '0;
    logic        parity_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        bus_req;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic        bus_burst;
    logic        done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Bench-side model state.
    int          cyc = 0;
    bit          mon_on = 0;
    bit          strict_done = 0;
    bit          hold_ack = 0;
    int          cur_cnt = 0;
    bit          cur_par = 0;
    logic [31:0] cur_base = '0;
    logic [1:0]  ack_mode = '0;
    bit          gap_mode = 0;
    logic [7:0]  cur_seed = '0;
    int          acc_bytes = 0;
    bit          prev_ready = 0;
    int          total_words = 0;
    int          burst_words = 0;
    int          exp_word = 0;
    bit          in_xfer = 0;
    bit          xfer_burst = 0;
    int          xfer_len = 0;
    int          beat = 0;
    int          acked = 0;
    bit          expect_low = 0;
    int          dchk = 0;
    bit          xfer_done = 0;

    always #10 clk = ~clk;

    dma_burst_packer u_dma_burst_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .parity_en(parity_en), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .bus_req(bus_req),
        .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_burst(bus_burst), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int i);
        return cur_seed + 8'(i * 29) + 8'(i >> 8);
    endfunction

    function automatic logic [31:0] word_of(input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            if (4 * w + k < cur_cnt) r[8*k +: 8] = byte_of(4 * w + k);
        end
        return r;
    endfunction

    function automatic logic [31:0] addr_of(input int w);
        return {cur_base[31:4], 4'h0} + 32'(4 * w);
    endfunction

    // One negedge process: byte source, bus slave and write checker.
    always @(negedge clk) begin
        bit ack_new;
        bit acc;
        int need;
        cyc++;
        if (mon_on) begin
            acc = in_valid && prev_ready;
            if (dchk == 1) begin
                chk(done == 1'b0, "R8", "done early", 32'(done), 0);
                dchk = 2;
            end else if (dchk == 2) begin
                chk(done == 1'b1, "R8", "done missing", 32'(done), 1);
                dchk = 3;
            end else if (dchk == 3) begin
                chk(done == 1'b0, "R8", "done longer than one clock", 32'(done), 0);
                dchk = 0;
                xfer_done = 1;
            end else if (strict_done && done) begin
                chk(0, "R8", "stray done", 1, 0);
            end
            if (expect_low) begin
                chk(bus_req == 1'b0, "R6", "request did not drop after transfer", 32'(bus_req), 0);
                expect_low = 0;
            end
            ack_new = hold_ack ? 1'b0 :
                      (ack_mode == 2'd0) ? 1'b1 :
                      (ack_mode == 2'd1) ? cyc[0] : ((cyc % 3) != 0);
            if (bus_req && !expect_low) begin
                if (!in_xfer) begin
                    if (exp_word >= total_words) begin
                        chk(0, "R2", "unexpected write", bus_addr, 0);
                    end else begin
                        in_xfer    = 1;
                        xfer_burst = (exp_word < burst_words);
                        xfer_len   = xfer_burst ? 4 : 1;
                        beat = 0;
                        acked = 0;
                        chk(bus_burst == xfer_burst, xfer_burst ? "R2" : "R6",
                            "burst flag", 32'(bus_burst), 32'(xfer_burst));
                        if (xfer_burst)
                            chk(acc_bytes >= 4 * (exp_word + 4), "R5", "burst before words present",
                                32'(acc_bytes), 32'(4 * (exp_word + 4)));
                        else
                            chk(acc_bytes >= cur_cnt, "R6", "single before all bytes in",
                                32'(acc_bytes), 32'(cur_cnt));
                    end
                end
                if (in_xfer && ack_new) begin
                    chk(bus_addr == addr_of(exp_word), "R4", "beat address", bus_addr, addr_of(exp_word));
                    chk(bus_data == word_of(exp_word), "R1", "beat data", bus_data, word_of(exp_word));
                    acked++;
                    need = (beat == 0) ? (cur_par ? 5 : 4) : 1;
                    if (acked == need) begin
                        exp_word++;
                        beat++;
                        acked = 0;
                        if (beat == xfer_len) begin
                            in_xfer = 0;
                            expect_low = 1;
                            if (exp_word == total_words) dchk = 1;
                        end
                    end
                end
            end else if (in_xfer && !bus_req) begin
                chk(0, "R3", "request dropped mid transfer", 0, 1);
                in_xfer = 0;
            end
            bus_ack = ack_new;
            if (acc) acc_bytes++;
            prev_ready = in_ready;
            if (acc_bytes < cur_cnt && !(gap_mode && (cyc % 3) == 1)) begin
                in_valid = 1'b1;
                in_data  = byte_of(acc_bytes);
            end else begin
                in_valid = 1'b0;
                in_data  = 8'h00;
            end
        end else begin
            bus_ack  = 1'b0;
            in_valid = 1'b0;
        end
    end

    task automatic run_xfer(input vec_t v, input bit extra, input int hold);
        int wd;
        @(negedge clk); #1;
        cur_cnt = int'(v.cnt); cur_par = v.par; cur_base = v.base;
        ack_mode = v.ackm; gap_mode = v.gap; cur_seed = v.seed;
        acc_bytes = 0; prev_ready = 0; exp_word = 0; in_xfer = 0; beat = 0;
        acked = 0; expect_low = 0; dchk = 0; xfer_done = 0;
        total_words = (cur_cnt + 3) / 4;
        burst_words = (total_words / 4) * 4;
        hold_ack = (hold != 0);
        strict_done = 1; mon_on = 1;
        start = 1'b1; start_addr = v.base; byte_count = v.cnt; parity_en = v.par;
        @(negedge clk); #1;
        start = 1'b0;
        if (extra) begin
            repeat (6) @(negedge clk);
            #1;
            start = 1'b1; start_addr = 32'hDEAD_BEE0; byte_count = 16'd4;
            @(negedge clk); #1;
            start = 1'b0;
        end
        if (hold != 0) begin
            repeat (hold) @(negedge clk);
            #1;
            chk(acc_bytes == 32, "R7", "bytes taken with bus stalled", 32'(acc_bytes), 32);
            chk(in_ready == 1'b0, "R7", "ready with FIFO full", 32'(in_ready), 0);
            chk(exp_word == 0, "R3", "beat completed without ack", 32'(exp_word), 0);
            hold_ack = 0;
        end
        wd = 0;
        while (!xfer_done && wd < 4000) begin
            @(negedge clk); #1;
            wd++;
        end
        chk(xfer_done, "R8", "job did not finish", 32'(xfer_done), 1);
        chk(exp_word == total_words, extra ? "R10" : "R2", "words written",
            32'(exp_word), 32'(total_words));
        chk(in_ready == 1'b0, "R12", "ready after job", 32'(in_ready), 0);
        strict_done = 0;
        mon_on = 0;
    endtask

    initial begin
        vec_t v;
        // R11: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk(bus_req == 1'b0 && done == 1'b0 && in_ready == 1'b0, "R11", "outputs in reset",
            {29'd0, bus_req, done, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(bus_req == 1'b0 && done == 1'b0 && in_ready == 1'b0, "R11", "outputs after reset",
            {29'd0, bus_req, done, in_ready}, 0);

        // Vector table.
        for (int i = 0; i < 8; i++) run_xfer(VECS[i], 1'b0, 0);

        // R10: a second start mid-job is ignored.
        v = VECS[2];
        v.seed = 8'hA5;
        run_xfer(v, 1'b1, 0);

        // R7: backpressure with the bus stalled.
        v = '{16'd40, 1'b1, 32'h0000_7004, 2'd0, 1'b0, 8'h3C};
        run_xfer(v, 1'b0, 100);

        // R9: zero byte count.
        @(negedge clk); #1;
        start = 1'b1; start_addr = 32'h0000_8000; byte_count = 16'd0; parity_en = 1'b0;
        @(negedge clk); #1;
        start = 1'b0;
        chk(done == 1'b0 && bus_req == 1'b0, "R9", "zero count first clock",
            {30'd0, done, bus_req}, 0);
        @(negedge clk); #1;
        chk(done == 1'b1 && bus_req == 1'b0, "R9", "zero count done",
            {30'd0, done, bus_req}, 32'h2);
        @(negedge clk); #1;
        chk(done == 1'b0 && in_ready == 1'b0, "R9", "zero count after done",
            {30'd0, done, in_ready}, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule